// File: doc/BRIEF.md
# Four-Input Lockable Round-Robin Leaf Cell

This cell is the bottom level of a tree of round-robin arbiters. It takes up to four local requesters and exposes one combined request to a parent node. When the parent acknowledges the cell, the cell picks one local requester and drives a one-hot grant to it. The winner comes from one of several fixed-priority encoders that all run in parallel. A small state value selects which encoder's answer is used. That state is the index of the most recently granted port, taken from the registered grant fed back into the cell. As a result, the port just served falls to the lowest priority and the port after it rises to the highest.

A round, as seen by this cell, ends with a grant to the highest-numbered port that is requesting at or after the rotation point. Such a grant sets a lock. While the lock is high, the cell withdraws its upward request and issues no grants, so the parent cannot serve it twice in the same parent round. The lock clears once the parent has dropped its acknowledge for one cycle. After that the cell requests again and carries on in wrap-around order from where it stopped.

Top module: `rr_leaf_cell`

## Requirements
- R1: Under synchronous active-high reset, `grant` is 0 and `lock` is 0. The rotation state after reset treats port 0 as the last served, so the first ordering is port 1, then 2, then 3, then 0. With requests 4'b0101 and an acknowledge, the first grant is 4'b0100.
- R2: `grant` is zero or one-hot, and any set bit matches a port that was requesting at the clock edge that produced it.
- R3: A grant is issued one clock after a cycle in which `ack` is high and `lock` is low. When `ack` is low, `grant` is zero and the rotation state is unchanged.
- R4: After port g is granted, the next grant goes to the first requesting port in the order g+1, g+2, g+3, g (modulo 4).
- R5: If all four ports request continuously, each round grants the ports in ascending index order, each exactly once, and the port just granted is never chosen next while another port is requesting.
- R6: `lock` rises on the same edge as a grant to port w when no port above w is requesting.
- R7: `up_req` equals the OR of `req` while `lock` is low, and is 0 while `lock` is high.
- R8: While `lock` is high, no grant is issued even if `ack` is high, and the rotation state is unchanged.
- R9: A clock edge with `lock` high and `ack` low clears `lock`.
- R10: With no requests, `grant` is zero and the rotation state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_REQ | Local request vector, bit i for port i |
| ack | input | 1 | Parent acknowledge: this cell may grant now |
| grant | output | NUM_REQ | Registered one-hot grant to local ports |
| up_req | output | 1 | Request to parent, masked by lock |
| lock | output | 1 | Local round complete; cell withdrawn |

## Verification
A corrupted rotation state shows up on the next acknowledged cycle with two or more requesters: the grant goes to the wrong port, visible one clock later. A lock that sticks or clears too early appears at once on `up_req` and on the suppression or leakage of the next grant. A reference model of the rotation and lock rules predicts every cycle of directed sweeps and a long pseudo-random request and acknowledge stream, so any divergence is caught within a cycle or two of its cause.

// File: rtl/rrl_pkg.sv
package rrl_pkg;
  localparam int unsigned RRL_DEF_PORTS = 4;

  function automatic int unsigned rrl_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rrl_prio_enc.sv
// Fixed-priority encoder whose top-priority port is START, then START+1, ...
module rrl_prio_enc #(
  parameter int unsigned N     = 4,
  parameter int unsigned START = 0
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win
);
  logic hit;

  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int o = 0; o < int'(N); o++) begin
      if (!hit && req[(int'(START) + o) % int'(N)]) begin
        win[(int'(START) + o) % int'(N)] = 1'b1;
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrl_order_sel.sv
// All orderings evaluated at once; the state picks one result.
module rrl_order_sel #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] state,
  output logic [N-1:0]     cand
);
  logic [N-1:0] cand_k [N];

  for (genvar k = 0; k < int'(N); k++) begin : g_enc
    rrl_prio_enc #(
      .N     (N),
      .START ((k + 1) % N)
    ) u_enc (
      .req (req),
      .win (cand_k[k])
    );
  end

  assign cand = cand_k[state];
endmodule

// File: rtl/rrl_round_ctl.sv
// Grant register, priority feedback and lock.
module rrl_round_ctl #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  input  logic             ack,
  input  logic [N-1:0]     cand,
  output logic [IDX_W-1:0] state,
  output logic [N-1:0]     grant,
  output logic             lock
);
  logic [N-1:0] prio_q;
  logic [N-1:0] grant_q;
  logic         lock_q;
  logic [N-1:0] above;
  logic         fire;
  logic         close_rnd;
  logic         run;

  // encode the one-hot feedback into the ordering select
  always_comb begin
    state = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (prio_q[i]) state = state | IDX_W'(i);
    end
  end

  // ports strictly above the candidate
  always_comb begin
    run = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      above[i] = run;
      run      = run | cand[i];
    end
  end

  assign fire      = ack && !lock_q && (|req);
  assign close_rnd = ~|(req & above);

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= N'(1);
      grant_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      grant_q <= fire ? cand : '0;
      if (fire) begin
        prio_q <= cand;
        lock_q <= close_rnd;
      end else if (lock_q && !ack) begin
        lock_q <= 1'b0;
      end
    end
  end

  assign grant = grant_q;
  assign lock  = lock_q;
endmodule

// File: rtl/rr_leaf_cell.sv
module rr_leaf_cell #(
  parameter int unsigned NUM_REQ = rrl_pkg::RRL_DEF_PORTS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic               ack,
  output logic [NUM_REQ-1:0] grant,
  output logic               up_req,
  output logic               lock
);
  localparam int unsigned IDX_W = rrl_pkg::rrl_idx_w(NUM_REQ);

  logic [IDX_W-1:0]   state;
  logic [NUM_REQ-1:0] cand;

  rrl_order_sel #(
    .N     (NUM_REQ),
    .IDX_W (IDX_W)
  ) u_sel (
    .req   (req),
    .state (state),
    .cand  (cand)
  );

  rrl_round_ctl #(
    .N     (NUM_REQ),
    .IDX_W (IDX_W)
  ) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .ack   (ack),
    .cand  (cand),
    .state (state),
    .grant (grant),
    .lock  (lock)
  );

  assign up_req = (|req) && !lock;
endmodule

// File: rtl/rr_leaf_cell_chk.sv
module rr_leaf_cell_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic         ack,
  input logic [N-1:0] grant,
  input logic         up_req,
  input logic         lock
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R2
  AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((grant & $past(req)) == grant)); // R2
  AST_GNT_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> $past(ack)); // R3
  AST_NO_GNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> !$past(lock)); // R8
  AST_LOCK_WITH_GNT: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> (grant != '0)); // R6
  AST_UP_MASKED: assert property (@(posedge clk) disable iff (rst)
    lock |-> !up_req); // R7
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($past(lock) && !$past(ack)) |-> !lock); // R9
  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ($past(req) != '0)); // R10
endmodule

bind rr_leaf_cell rr_leaf_cell_chk #(.N(NUM_REQ)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .ack    (ack),
  .grant  (grant),
  .up_req (up_req),
  .lock   (lock)
);

// File: tb/rr_leaf_cell_tb.sv
module rr_leaf_cell_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic       ack = 1'b0;
  logic [3:0] grant;
  logic       up_req;
  logic       lock;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] g;
    logic       l;
    logic       u;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int m_ptr  = 0;
  bit m_lock = 1'b0;

  always #10 clk = ~clk;

  rr_leaf_cell u_dut (
    .clk(clk), .rst(rst), .req(req), .ack(ack),
    .grant(grant), .up_req(up_req), .lock(lock)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and predict its outcome
  task automatic step(input logic [3:0] r, input logic a, input string tag);
    exp_t e;
    int   win;
    bit   fire;
    bit   closes;
    @(negedge clk);
    req = r;
    ack = a;
    fire = a && !m_lock && (r != 0);
    e.g  = '0;
    if (fire) begin
      win = -1;
      for (int o = 1; o <= 4; o++) begin
        if (win < 0 && r[(m_ptr + o) % 4]) win = (m_ptr + o) % 4;
      end
      closes = 1'b1;
      for (int j = win + 1; j < 4; j++) if (r[j]) closes = 1'b0;
      e.g    = 4'(1 << win);
      m_ptr  = win;
      m_lock = closes;
    end else if (m_lock && !a) begin
      m_lock = 1'b0;
    end
    e.l   = m_lock;
    e.u   = (r != 0) && !m_lock;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "grant", int'(grant), int'(e.g));
        check(e.tag, "lock", int'(lock), int'(e.l));
        check(e.tag, "up_req", int'(up_req), int'(e.u));
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    check("R1", "grant in reset", int'(grant), 0);
    check("R1", "lock in reset", int'(lock), 0);
    rst = 1'b0;
    // R1 first ordering after reset; R6 nothing above port 2 -> lock
    step(4'b0101, 1'b1, "R1");
    // R8 locked: no grant even with ack
    step(4'b0101, 1'b1, "R8");
    // R9 ack low while locked clears lock; R7 up_req returns
    step(4'b0101, 1'b0, "R9");
    // R4 after port 2: order 3,0,1,2 -> port 0
    step(4'b0101, 1'b1, "R4");
    step(4'b0101, 1'b1, "R4");
    // R10 idle, and R9 lock release
    step(4'b0000, 1'b0, "R10");
    step(4'b0000, 1'b1, "R10");
    // R5 full sweeps with all ports requesting
    for (int k = 0; k < 3; k++) begin
      step(4'b1111, 1'b1, "R5");
      step(4'b1111, 1'b1, "R5");
      step(4'b1111, 1'b1, "R5");
      step(4'b1111, 1'b1, "R5");
      step(4'b1111, 1'b0, "R5");
    end
    // R3 ack low holds state, then resumes
    step(4'b0110, 1'b0, "R3");
    step(4'b0110, 1'b0, "R3");
    step(4'b0110, 1'b1, "R3");
    // R7 up_req follows requests with lock low
    step(4'b1000, 1'b0, "R7");
    step(4'b0000, 1'b0, "R7");
    // R2 mixed pseudo-random stream
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0], lf[5] | lf[7], "R2");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule